// File: doc/BRIEF.md
# Analog Memory Block Allocator

This block issues write and read addresses for a switched-capacitor sample memory. The memory has 96 cells per channel, split into 12 blocks of 8 cells. A write pointer steps one cell per sample clock and moves only through blocks that are not held. Each cell address is given in Gray code.

A local trigger holds two blocks: the block being written and the next free block after it. The writer finishes both blocks, which captures the pulse, and then skips them on later laps. Each held pair joins a six-entry queue in arrival order. A level-1 accept on the head pair starts a 16-cell read. The writer keeps running while the read takes place. A readout-done handshake frees the pair. A pair that gets no accept within a programmable number of clocks is discarded and freed. A trigger that cannot be served is dropped and sets a sticky overflow flag.

Top module: `amem_block_alloc`

## Requirements
- R1: After reset, wr_addr_o is 0, wr_en_o is 1, rd_vld_o is 0, q_cnt_o is 0 and overflow_o is 0.
- R2: When no blocks are held, each clock moves the write cell index by one and wraps from 95 to 0. wr_addr_o is the Gray code of the index (index xor index>>1), where index = block*8 + cell.
- R3: An accepted trigger holds the current block and the next free block after it. Writing goes on through the rest of the current block, then through the whole second block, and then to the next free block. Held blocks are skipped on later laps.
- R4: A trigger is dropped when any of these holds: the writer's current block is held, fewer than 2 blocks are free, or the queue has 6 entries. A dropped trigger sets overflow_o, and only reset clears it. Acceptance with exactly 2 free blocks succeeds.
- R5: Held pairs leave the queue in the order they were reserved. q_head_a_o and q_head_b_o give the first and second block of the head pair. q_cnt_o gives the number of queued pairs.
- R6: l1a_i is acted on only while the head pair waits. It starts 16 read clocks with rd_vld_o high, and rd_addr_o gives the Gray code of cells 0..7 of the first block and then cells 0..7 of the second. l1a_i has no effect when the queue is empty.
- R7: After its read, a pair stays held until rd_done_i is high, and then it is freed and leaves the queue on that edge.
- R8: A waiting head pair is discarded and freed on the clock edge where its wait age equals tmo_i. The age is 0 on the first waiting edge. An l1a_i on that same edge takes priority. With tmo_i = 0, a pair is discarded on its first waiting edge.
- R9: If no block is free at the end of a block, writing stalls. wr_en_o goes low and wr_addr_o holds. One edge after a block is freed, writing resumes at cell 0 of the next free block.
- R10: Writes continue at one cell per clock while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Local trigger pulse |
| l1a_i | input | 1 | Level-1 accept for the head pair |
| rd_done_i | input | 1 | Digitisation of the head pair finished |
| tmo_i | input | 8 | Wait limit in clocks before discard |
| wr_addr_o | output | 7 | Gray-coded write cell address |
| wr_en_o | output | 1 | Writing active (low while stalled) |
| rd_addr_o | output | 7 | Gray-coded read cell address |
| rd_vld_o | output | 1 | rd_addr_o is valid |
| q_cnt_o | output | 3 | Number of queued pairs |
| q_head_a_o | output | 4 | First block of the head pair |
| q_head_b_o | output | 4 | Second block of the head pair |
| overflow_o | output | 1 | Sticky dropped-trigger flag |

## Verification
The assertions assume that tmo_i stays stable while a pair is waiting. They also assume that rd_done_i and l1a_i may arrive at any time, because the design ignores them outside the relevant state. The stimulus changes tmo_i only right after a reset. The triggers are timed by the observed write address, so every accept and every drop lands on a known block and cell. rd_done_i is raised only after the 16 read clocks have been seen.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
  typedef enum logic [1:0] {RS_WAIT, RS_READ, RS_DONE} rd_state_t;
endpackage

// File: rtl/amem_blk_mask.sv
`timescale 1ns/1ps
module amem_blk_mask #(
  parameter int NBLK = 12,
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en_i,
  input  logic [BW-1:0]   set_a_i,
  input  logic [BW-1:0]   set_b_i,
  input  logic            clr_en_i,
  input  logic [BW-1:0]   clr_a_i,
  input  logic [BW-1:0]   clr_b_i,
  output logic [NBLK-1:0] rsv_o
);
  logic [NBLK-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (set_en_i) begin
      set_v[set_a_i] = 1'b1;
      set_v[set_b_i] = 1'b1;
    end
    if (clr_en_i) begin
      clr_v[clr_a_i] = 1'b1;
      clr_v[clr_b_i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsv_o <= '0;
    else        rsv_o <= (rsv_o | set_v) & ~clr_v;
  end

  // R3: only free, distinct blocks get held
  a_r3_hold_free_pair: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |-> (!rsv_o[set_a_i] && !rsv_o[set_b_i] && set_a_i != set_b_i));
  // R7: only held blocks get released
  a_r7_release_held: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |-> (rsv_o[clr_a_i] && rsv_o[clr_b_i]));
endmodule

// File: rtl/amem_wr_ptr.sv
`timescale 1ns/1ps
module amem_wr_ptr #(
  parameter int NBLK  = 12,
  parameter int CELLS = 8,
  localparam int BW = $clog2(NBLK),
  localparam int CW = $clog2(CELLS),
  localparam int AW = $clog2(NBLK*CELLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            q_full_i,
  input  logic [NBLK-1:0] rsv_i,
  output logic            trig_acc_o,
  output logic            trig_drop_o,
  output logic [BW-1:0]   pair_a_o,
  output logic [BW-1:0]   pair_b_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            wr_en_o
);
  localparam logic [CW-1:0] LAST_CELL = CW'(CELLS-1);

  function automatic logic [BW:0] find_free(input logic [NBLK-1:0] fr,
                                            input logic [BW-1:0] from,
                                            input int span);
    logic [BW:0] r;
    r = '0;
    for (int k = 1; k <= NBLK; k++) begin
      int j;
      j = (int'(from) + k) % NBLK;
      if (k <= span && !r[BW] && fr[BW'(j)]) r = {1'b1, BW'(j)};
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [BW-1:0] wr_blk, follow_blk;
  logic [CW-1:0] wr_cell;
  logic          wr_on, follow_vld;
  logic [NBLK-1:0] fr;
  logic [BW:0]   nf_any, nf_other;
  logic          blk_end;

  assign fr          = ~rsv_i;
  assign nf_any      = find_free(fr, wr_blk, NBLK);
  assign nf_other    = find_free(fr, wr_blk, NBLK-1);
  assign blk_end     = wr_on && (wr_cell == LAST_CELL);
  assign trig_acc_o  = trig_i && fr[wr_blk] && nf_other[BW] && !q_full_i;
  assign trig_drop_o = trig_i && !trig_acc_o;
  assign pair_a_o    = wr_blk;
  assign pair_b_o    = nf_other[BW-1:0];
  assign wr_addr_o   = gray(AW'(wr_blk) * AW'(CELLS) + AW'(wr_cell));
  assign wr_en_o     = wr_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_blk     <= '0;
      wr_cell    <= '0;
      wr_on      <= 1'b1;
      follow_vld <= 1'b0;
      follow_blk <= '0;
    end else if (!wr_on) begin
      if (nf_any[BW]) begin
        wr_blk  <= nf_any[BW-1:0];
        wr_cell <= '0;
        wr_on   <= 1'b1;
      end
    end else if (blk_end) begin
      if (trig_acc_o) begin
        wr_blk  <= nf_other[BW-1:0];
        wr_cell <= '0;
      end else if (follow_vld) begin
        wr_blk     <= follow_blk;
        wr_cell    <= '0;
        follow_vld <= 1'b0;
      end else if (nf_any[BW]) begin
        wr_blk  <= nf_any[BW-1:0];
        wr_cell <= '0;
      end else begin
        wr_on <= 1'b0;
      end
    end else begin
      wr_cell <= wr_cell + CW'(1);
      if (trig_acc_o) begin
        follow_vld <= 1'b1;
        follow_blk <= nf_other[BW-1:0];
      end
    end
  end

  // R2: inside a block the cell steps by one and the block holds
  a_r2_cell_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && wr_cell != LAST_CELL) |=> (wr_cell == $past(wr_cell) + CW'(1) && wr_blk == $past(wr_blk)));
  // R9: writing resumes at the start of a block
  a_r9_resume_cell0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_on) |-> wr_cell == '0);
  // R9: a stalled writer keeps its address
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_on && !nf_any[BW]) |=> $stable(wr_addr_o));
endmodule

// File: rtl/amem_pair_fifo.sv
`timescale 1ns/1ps
module amem_pair_fifo #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [QW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign head_o  = mem[rp];
  assign full_o  = (cnt_o == QW'(DEPTH));
  assign empty_o = (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) begin
        mem[wp] <= din_i;
        wp      <= bump(wp);
      end
      if (pop_i) rp <= bump(rp);
      if (push_i && !pop_i)      cnt_o <= cnt_o + QW'(1);
      else if (pop_i && !push_i) cnt_o <= cnt_o - QW'(1);
    end
  end

  // R5: queue never written when full nor read when empty
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/amem_rd_seq.sv
`timescale 1ns/1ps
module amem_rd_seq
  import amem_pkg::*;
#(
  parameter int NBLK  = 12,
  parameter int CELLS = 8,
  parameter int TW    = 8,
  localparam int BW = $clog2(NBLK),
  localparam int CW = $clog2(CELLS),
  localparam int AW = $clog2(NBLK*CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty_i,
  input  logic [BW-1:0] head_a_i,
  input  logic [BW-1:0] head_b_i,
  input  logic          l1a_i,
  input  logic          rd_done_i,
  input  logic [TW-1:0] tmo_i,
  output logic          pop_o,
  output logic          discard_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_vld_o
);
  function automatic logic [AW-1:0] gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  rd_state_t     st;
  logic [TW-1:0] age;
  logic [CW:0]   ridx;
  logic          start, waiting;
  logic [BW-1:0] rblk;

  assign waiting   = (st == RS_WAIT) && !q_empty_i;
  assign start     = waiting && l1a_i;
  assign discard_o = waiting && !l1a_i && (age == tmo_i);
  assign pop_o     = discard_o || ((st == RS_DONE) && rd_done_i);
  assign rblk      = ridx[CW] ? head_b_i : head_a_i;
  assign rd_addr_o = gray(AW'(rblk) * AW'(CELLS) + AW'(ridx[CW-1:0]));
  assign rd_vld_o  = (st == RS_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RS_WAIT;
      age  <= '0;
      ridx <= '0;
    end else begin
      unique case (st)
        RS_WAIT: begin
          if (start) begin
            st   <= RS_READ;
            ridx <= '0;
            age  <= '0;
          end else if (discard_o || q_empty_i) age <= '0;
          else                                 age <= age + TW'(1);
        end
        RS_READ: begin
          if (ridx == (CW+1)'(2*CELLS-1)) st <= RS_DONE;
          else                            ridx <= ridx + (CW+1)'(1);
        end
        default: begin
          if (rd_done_i) begin
            st  <= RS_WAIT;
            age <= '0;
          end
        end
      endcase
    end
  end

  // R6: a read only runs with a pair in the queue
  a_r6_read_has_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> !q_empty_i);
  // R7: the pair being read stays at the head
  a_r7_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld_o && $past(rd_vld_o)) |-> ($stable(head_a_i) && $stable(head_b_i)));
  // R8: a discard only happens to a waiting pair
  a_r8_discard_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> (st == RS_WAIT && !q_empty_i));
endmodule

// File: rtl/amem_block_alloc.sv
`timescale 1ns/1ps
module amem_block_alloc #(
  parameter int NBLK  = 12,
  parameter int CELLS = 8,
  parameter int DEPTH = 6,
  parameter int TW    = 8,
  localparam int BW = $clog2(NBLK),
  localparam int AW = $clog2(NBLK*CELLS),
  localparam int QW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          l1a_i,
  input  logic          rd_done_i,
  input  logic [TW-1:0] tmo_i,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_vld_o,
  output logic [QW-1:0] q_cnt_o,
  output logic [BW-1:0] q_head_a_o,
  output logic [BW-1:0] q_head_b_o,
  output logic          overflow_o
);
  logic [NBLK-1:0] rsv;
  logic            trig_acc, trig_drop, pair_pop, pair_discard;
  logic [BW-1:0]   pair_a, pair_b;
  logic            q_full, q_empty;
  logic [2*BW-1:0] q_head;

  assign q_head_a_o = q_head[2*BW-1:BW];
  assign q_head_b_o = q_head[BW-1:0];

  amem_blk_mask #(.NBLK(NBLK)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_en_i(trig_acc), .set_a_i(pair_a), .set_b_i(pair_b),
    .clr_en_i(pair_pop), .clr_a_i(q_head_a_o), .clr_b_i(q_head_b_o),
    .rsv_o(rsv));

  amem_wr_ptr #(.NBLK(NBLK), .CELLS(CELLS)) u_wr (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .q_full_i(q_full),
    .rsv_i(rsv), .trig_acc_o(trig_acc), .trig_drop_o(trig_drop),
    .pair_a_o(pair_a), .pair_b_o(pair_b),
    .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o));

  amem_pair_fifo #(.DEPTH(DEPTH), .DW(2*BW)) u_q (
    .clk(clk), .rst_n(rst_n), .push_i(trig_acc), .din_i({pair_a, pair_b}),
    .pop_i(pair_pop), .head_o(q_head), .cnt_o(q_cnt_o),
    .full_o(q_full), .empty_o(q_empty));

  amem_rd_seq #(.NBLK(NBLK), .CELLS(CELLS), .TW(TW)) u_rd (
    .clk(clk), .rst_n(rst_n), .q_empty_i(q_empty),
    .head_a_i(q_head_a_o), .head_b_i(q_head_b_o),
    .l1a_i(l1a_i), .rd_done_i(rd_done_i), .tmo_i(tmo_i),
    .pop_o(pair_pop), .discard_o(pair_discard),
    .rd_addr_o(rd_addr_o), .rd_vld_o(rd_vld_o));

  always_ff @(posedge clk) begin
    if (!rst_n) overflow_o <= 1'b0;
    else if (trig_drop) overflow_o <= 1'b1;
  end

  // R4: overflow is sticky until reset
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R4: a dropped trigger leaves the queue length unchanged
  a_r4_drop_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_drop && !pair_pop) |=> $stable(q_cnt_o));
  // R8: a discarded pair leaves the queue on that edge
  a_r8_discard_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_discard && !trig_acc) |=> q_cnt_o == $past(q_cnt_o) - QW'(1));
endmodule

// File: tb/amem_block_alloc_tb.sv
`timescale 1ns/1ps
module amem_block_alloc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0, l1a = 1'b0, done = 1'b0;
  logic [7:0] tmo = 8'd255;
  logic [6:0] wr_addr, rd_addr;
  logic       wr_en, rd_vld, ovf;
  logic [2:0] q_cnt;
  logic [3:0] qa, qb;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  amem_block_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .l1a_i(l1a), .rd_done_i(done),
    .tmo_i(tmo), .wr_addr_o(wr_addr), .wr_en_o(wr_en), .rd_addr_o(rd_addr),
    .rd_vld_o(rd_vld), .q_cnt_o(q_cnt), .q_head_a_o(qa), .q_head_b_o(qb),
    .overflow_o(ovf));

  function automatic logic [6:0] gcode(input int v);
    logic [7:0] b;
    logic [6:0] g;
    b = 8'(v);
    for (int i = 0; i < 7; i++) g[i] = b[i] ^ b[i+1];
    return g;
  endfunction

  function automatic int ungray(input logic [6:0] g);
    logic [6:0] b;
    b[6] = g[6];
    for (int i = 5; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig = 1'b0; l1a = 1'b0; done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic wait_idx(input int t);
    for (int k = 0; k < 200; k++) begin
      if (ungray(wr_addr) == t) break;
      tick();
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0;
  endtask

  // R1 and R2
  task automatic t_reset_and_run();
    tmo = 8'd255;
    do_reset();
    chk(wr_addr == 7'd0, "R1 wr_addr", int'(wr_addr), 0);
    chk(wr_en == 1'b1, "R1 wr_en", int'(wr_en), 1);
    chk(rd_vld == 1'b0, "R1 rd_vld", int'(rd_vld), 0);
    chk(q_cnt == 3'd0, "R1 q_cnt", int'(q_cnt), 0);
    chk(ovf == 1'b0, "R1 overflow", int'(ovf), 0);
    for (int e = 0; e < 100; e++) begin
      chk(wr_addr == gcode(e % 96), "R2 gray step", int'(wr_addr), int'(gcode(e % 96)));
      tick();
    end
  endtask

  // R3: capture then skip of held blocks
  task automatic t_capture();
    int e;
    tmo = 8'd255;
    do_reset();
    wait_idx(3);
    pulse_trig();
    chk(q_cnt == 3'd1, "R3 queued", int'(q_cnt), 1);
    chk(qa == 4'd0 && qb == 4'd1, "R3 pair", int'(qa)*16 + int'(qb), 1);
    e = 4;
    for (int k = 0; k < 97; k++) begin
      chk(ungray(wr_addr) == e, "R3 write order", ungray(wr_addr), e);
      tick();
      e = (e == 95) ? 16 : e + 1;
    end
  endtask

  // R6, R7, R10
  task automatic t_readout();
    int w;
    tmo = 8'd255;
    do_reset();
    l1a = 1'b1; tick(); l1a = 1'b0;
    chk(rd_vld == 1'b0, "R6 accept on empty ignored", int'(rd_vld), 0);
    wait_idx(3);
    pulse_trig();
    repeat (2) tick();
    l1a = 1'b1; tick(); l1a = 1'b0;
    for (int i = 0; i < 16; i++) begin
      w = ungray(wr_addr);
      chk(rd_vld == 1'b1, "R6 read valid", int'(rd_vld), 1);
      chk(rd_addr == gcode(i), "R6 read address", int'(rd_addr), int'(gcode(i)));
      tick();
      chk(wr_en && ungray(wr_addr) == (w + 1) % 96, "R10 write during read", ungray(wr_addr), (w + 1) % 96);
    end
    chk(rd_vld == 1'b0, "R6 read ends after 16", int'(rd_vld), 0);
    repeat (3) tick();
    chk(q_cnt == 3'd1, "R7 held until done", int'(q_cnt), 1);
    done = 1'b1; tick(); done = 1'b0;
    chk(q_cnt == 3'd0, "R7 freed on done", int'(q_cnt), 0);
    wait_idx(95);
    tick();
    chk(ungray(wr_addr) == 0, "R7 freed block reused", ungray(wr_addr), 0);
  endtask

  // R8
  task automatic t_timeout();
    tmo = 8'd5;
    do_reset();
    wait_idx(3);
    pulse_trig();
    repeat (5) tick();
    chk(q_cnt == 3'd1, "R8 kept before limit", int'(q_cnt), 1);
    tick();
    chk(q_cnt == 3'd0, "R8 discard at limit", int'(q_cnt), 0);
    do_reset();
    wait_idx(3);
    pulse_trig();
    repeat (5) tick();
    l1a = 1'b1; tick(); l1a = 1'b0;
    chk(rd_vld == 1'b1, "R8 accept wins at limit", int'(rd_vld), 1);
    chk(q_cnt == 3'd1, "R8 no discard on accept", int'(q_cnt), 1);
    tmo = 8'd0;
    do_reset();
    pulse_trig();
    chk(q_cnt == 3'd1, "R8 zero limit queued", int'(q_cnt), 1);
    tick();
    chk(q_cnt == 3'd0, "R8 zero limit discard", int'(q_cnt), 0);
  endtask

  // R4, R5, R9
  task automatic t_fill();
    tmo = 8'd255;
    do_reset();
    for (int p = 0; p < 6; p++) begin
      wait_idx(p == 0 ? 3 : p * 16);
      pulse_trig();
    end
    chk(q_cnt == 3'd6, "R5 six pairs", int'(q_cnt), 6);
    chk(qa == 4'd0 && qb == 4'd1, "R5 oldest at head", int'(qa)*16 + int'(qb), 1);
    chk(ovf == 1'b0, "R4 no false overflow", int'(ovf), 0);
    for (int k = 0; k < 40; k++) begin
      if (!wr_en) break;
      tick();
    end
    chk(wr_en == 1'b0, "R9 stall", int'(wr_en), 0);
    chk(wr_addr == gcode(95), "R9 stall address", int'(wr_addr), int'(gcode(95)));
    pulse_trig();
    chk(ovf == 1'b1, "R4 dropped sets flag", int'(ovf), 1);
    chk(q_cnt == 3'd6, "R4 dropped not queued", int'(q_cnt), 6);
    l1a = 1'b1; tick(); l1a = 1'b0;
    chk(rd_addr == gcode(0) && rd_vld, "R6 head read", int'(rd_addr), int'(gcode(0)));
    repeat (16) tick();
    done = 1'b1; tick(); done = 1'b0;
    chk(q_cnt == 3'd5, "R5 pop count", int'(q_cnt), 5);
    chk(qa == 4'd2 && qb == 4'd3, "R5 next pair", int'(qa)*16 + int'(qb), 2*16 + 3);
    chk(wr_en == 1'b0, "R9 still stalled on free edge", int'(wr_en), 0);
    tick();
    chk(wr_en == 1'b1, "R9 resume", int'(wr_en), 1);
    chk(wr_addr == gcode(0), "R9 resume at cell 0", int'(wr_addr), 0);
    pulse_trig();
    chk(q_cnt == 3'd6, "R4 accept with two free", int'(q_cnt), 6);
    chk(ovf == 1'b1, "R4 sticky", int'(ovf), 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset_and_run();
    t_capture();
    t_readout();
    t_timeout();
    t_fill();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule